// File: doc/BRIEF.md
# H-Bridge Mode Decoder and Fault Supervisor

This block turns a two-bit drive command into gate enables for the four switches of an H-bridge. It also watches four synchronous protection flags and drives one active-low fault line. Each bridge leg has a high-side and a low-side switch. The command selects one of four modes: idle with all switches open, one of two drive directions, or brake. During the off phase of the duty regulator, a driving bridge closes both high-side switches and opens both low-side switches, so that the winding current circulates through the top of the bridge.

The block applies three recovery policies:
- A current-limit flag that stays high for a long time is reported on the fault line, but the bridge keeps driving. The report clears as soon as the flag drops, or when the bridge goes idle.
- An overcurrent flag that persists past a short filter latches a shutdown. Only an undervoltage event clears it.
- An overtemperature flag and an undervoltage flag shut the bridge down only while they are high. Undervoltage also returns all internal state to its reset values.

The fault line also goes low for a short pulse each time the bridge leaves idle. The command inputs pass through a synchroniser chain before they are decoded. Each leg inserts a dead time whenever it moves from one switch to the other.

Top module: `hbridge_supervisor`

## Requirements
- R1: With the synchronised command {dir_a,dir_b}, 2'b00 opens all four switches. 2'b10 drives leg A high and leg B low. 2'b01 drives leg A low and leg B high. 2'b11 drives both legs high.
- R2: When pwm_on is 0 in either drive direction (2'b10 or 2'b01), both high-side enables are 1 and both low-side enables are 0.
- R3: The high-side and low-side enables of one leg are never both 1. When a leg moves directly from one switch to the other, both of its enables are 0 for exactly DEAD_CYCLES cycles.
- R4: A command change applied before clock edge 1 reaches the gate enables at edge SYNC_STAGES+1, when it starts from all switches open.
- R5: ilim_flag held high for ILIM_CYCLES consecutive edges drives fault_n to 0 while the gates keep following the command. fault_n returns to 1 one edge after the flag drops. An idle command also clears the indication, even while the flag stays high.
- R6: ocp_flag held high for OCP_CYCLES consecutive edges drives fault_n to 0, and all gates are 0 from the following edge. This state survives removal of the flag and any command, including idle.
- R7: While ot_flag is 1, fault_n is 0 and all gates are 0 from the next edge. When the flag drops, normal driving resumes without any other action.
- R8: While uv_flag is 1, fault_n is 0 and all gates are 0 from the next edge. It clears a latched overcurrent shutdown.
- R9: Each change of the synchronised command from 2'b00 to any other value drives fault_n to 0 for exactly PULSE_CYCLES cycles.
- R10: bridge_active is 1 exactly when the synchronised command is not 2'b00 and no shutdown (R6, R7, R8) is in force.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dir_a | input | 1 | Command bit that selects leg A high |
| dir_b | input | 1 | Command bit that selects leg B high |
| pwm_on | input | 1 | Duty regulator on-phase strobe (synchronous) |
| ilim_flag | input | 1 | Current-limit comparator flag (synchronous) |
| ocp_flag | input | 1 | Overcurrent comparator flag (synchronous) |
| ot_flag | input | 1 | Overtemperature flag (synchronous) |
| uv_flag | input | 1 | Undervoltage flag (synchronous) |
| gate_a_hi | output | 1 | Leg A high-side enable |
| gate_a_lo | output | 1 | Leg A low-side enable |
| gate_b_hi | output | 1 | Leg B high-side enable |
| gate_b_lo | output | 1 | Leg B low-side enable |
| bridge_active | output | 1 | Bridge is commanded on and not shut down |
| fault_n | output | 1 | Active-low fault indication |

## Verification
The assertions assume the following about the inputs:
- The four protection flags and pwm_on are already synchronous to clk. Only the command bits go through the synchroniser.
- DEAD_CYCLES and PULSE_CYCLES are at least one, so that a leg's switch change always passes through an all-open cycle.

The random phase holds each command, strobe and overtemperature setting for longer than the synchroniser, the dead time and the sleep-exit pulse together take. The directed cases raise one protection flag at a time and count edges against the persistence limits. This keeps every expected value independent of when a transition falls within a window.

// File: rtl/hbs_pkg.sv
package hbs_pkg;

    typedef enum logic [1:0] {
        LEG_OFF = 2'd0,
        LEG_HI  = 2'd1,
        LEG_LO  = 2'd2
    } leg_sel_e;

    typedef struct packed {
        leg_sel_e a;
        leg_sel_e b;
    } bridge_tgt_t;

    // cmd = {dir_a, dir_b}
    function automatic bridge_tgt_t decode_cmd(input logic [1:0] cmd, input logic pwm_on);
        bridge_tgt_t t;
        unique case (cmd)
            2'b00:   begin t.a = LEG_OFF; t.b = LEG_OFF; end
            2'b10:   begin t.a = LEG_HI;  t.b = pwm_on ? LEG_LO : LEG_HI; end
            2'b01:   begin t.a = pwm_on ? LEG_LO : LEG_HI; t.b = LEG_HI; end
            default: begin t.a = LEG_HI;  t.b = LEG_HI; end
        endcase
        return t;
    endfunction

endpackage

// File: rtl/hbs_sync.sv
module hbs_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stg_d [STAGES];
    logic [WIDTH-1:0] stg_q [STAGES];

    always_comb begin
        stg_d[0] = clr ? '0 : d;
        for (int i = 1; i < STAGES; i++) begin
            stg_d[i] = clr ? '0 : stg_q[i-1];
        end
    end

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg_q[g] <= '0;
                else        stg_q[g] <= stg_d[g];
            end
        end
    endgenerate

    assign q = stg_q[STAGES-1];
endmodule

// File: rtl/hbs_persist.sv
module hbs_persist #(
    parameter int LIMIT = 300
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic flag,
    output logic hit
);
    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr || !flag)               cnt_d = '0;
        else if (cnt_q != CW'(LIMIT))   cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign hit = (cnt_q == CW'(LIMIT));

    AST_PERSIST_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        !flag |=> !hit); // R5
endmodule

// File: rtl/hbs_leg.sv
module hbs_leg
    import hbs_pkg::*;
#(
    parameter int DEAD = 2
) (
    input  logic     clk,
    input  logic     rst_n,
    input  leg_sel_e tgt,
    output logic     hs,
    output logic     ls
);
    localparam int DW = $clog2(DEAD + 1);

    typedef struct packed {
        leg_sel_e      cur;
        logic [DW-1:0] cnt;
    } leg_st_t;

    leg_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (tgt == st_q.cur) begin
            if (st_q.cnt != '0) st_d.cnt = st_q.cnt - 1'b1;
        end else if (st_q.cur != LEG_OFF) begin
            st_d.cur = LEG_OFF;
            st_d.cnt = DW'(DEAD - 1);
        end else if (st_q.cnt == '0) begin
            st_d.cur = tgt;
        end else begin
            st_d.cnt = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{cur: LEG_OFF, cnt: '0};
        else        st_q <= st_d;
    end

    assign hs = (st_q.cur == LEG_HI);
    assign ls = (st_q.cur == LEG_LO);

    AST_LEG_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(hs && ls)); // R3
    AST_LEG_GAP_LO: assert property (@(posedge clk) disable iff (!rst_n)
        ls |-> !$past(hs)); // R3
    AST_LEG_GAP_HI: assert property (@(posedge clk) disable iff (!rst_n)
        hs |-> !$past(ls)); // R3
endmodule

// File: rtl/hbridge_supervisor.sv
module hbridge_supervisor
    import hbs_pkg::*;
#(
    parameter int SYNC_STAGES  = 2,
    parameter int DEAD_CYCLES  = 2,
    parameter int PULSE_CYCLES = 4,
    parameter int ILIM_CYCLES  = 27_500_000,
    parameter int OCP_CYCLES   = 300
) (
    input  logic clk,
    input  logic rst_n,
    input  logic dir_a,
    input  logic dir_b,
    input  logic pwm_on,
    input  logic ilim_flag,
    input  logic ocp_flag,
    input  logic ot_flag,
    input  logic uv_flag,
    output logic gate_a_hi,
    output logic gate_a_lo,
    output logic gate_b_hi,
    output logic gate_b_lo,
    output logic bridge_active,
    output logic fault_n
);
    localparam int PW = $clog2(PULSE_CYCLES + 1);

    typedef struct packed {
        logic          ocp_lat;
        logic          prev_sleep;
        logic [PW-1:0] pulse_cnt;
    } sup_st_t;

    sup_st_t     st_d, st_q;
    logic [1:0]  cmd_s;
    logic        sleep_now;
    logic        ilim_hit;
    logic        ocp_hit;
    logic        exit_now;
    logic        shutdown;
    bridge_tgt_t tgt;

    hbs_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) i_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (uv_flag),
        .d    ({dir_a, dir_b}),
        .q    (cmd_s)
    );

    assign sleep_now = (cmd_s == 2'b00);

    hbs_persist #(.LIMIT(ILIM_CYCLES)) i_ilim (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (uv_flag || sleep_now),
        .flag (ilim_flag),
        .hit  (ilim_hit)
    );

    hbs_persist #(.LIMIT(OCP_CYCLES)) i_ocp (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (uv_flag),
        .flag (ocp_flag),
        .hit  (ocp_hit)
    );

    always_comb begin
        st_d     = st_q;
        exit_now = st_q.prev_sleep && !sleep_now && !uv_flag;
        if (uv_flag) begin
            st_d.ocp_lat    = 1'b0;
            st_d.prev_sleep = 1'b1;
            st_d.pulse_cnt  = '0;
        end else begin
            st_d.ocp_lat    = st_q.ocp_lat || ocp_hit;
            st_d.prev_sleep = sleep_now;
            if (exit_now)                 st_d.pulse_cnt = PW'(PULSE_CYCLES - 1);
            else if (st_q.pulse_cnt != '0) st_d.pulse_cnt = st_q.pulse_cnt - 1'b1;
        end
        shutdown = uv_flag || ot_flag || ocp_hit || st_q.ocp_lat;
        if (shutdown) begin
            tgt.a = LEG_OFF;
            tgt.b = LEG_OFF;
        end else begin
            tgt = decode_cmd(cmd_s, pwm_on);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{ocp_lat: 1'b0, prev_sleep: 1'b1, pulse_cnt: '0};
        else        st_q <= st_d;
    end

    hbs_leg #(.DEAD(DEAD_CYCLES)) i_leg_a (
        .clk  (clk),
        .rst_n(rst_n),
        .tgt  (tgt.a),
        .hs   (gate_a_hi),
        .ls   (gate_a_lo)
    );

    hbs_leg #(.DEAD(DEAD_CYCLES)) i_leg_b (
        .clk  (clk),
        .rst_n(rst_n),
        .tgt  (tgt.b),
        .hs   (gate_b_hi),
        .ls   (gate_b_lo)
    );

    assign bridge_active = !sleep_now && !shutdown;
    assign fault_n = !(shutdown || ilim_hit || exit_now || (st_q.pulse_cnt != '0));

    AST_OCP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ocp_lat && !uv_flag) |=> st_q.ocp_lat); // R6
    AST_UV_GATES_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        uv_flag |=> !(gate_a_hi || gate_a_lo || gate_b_hi || gate_b_lo)); // R8
    AST_OT_GATES_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        ot_flag |=> !(gate_a_hi || gate_a_lo || gate_b_hi || gate_b_lo)); // R7
    AST_SLEEP_GATES_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_now |=> !(gate_a_hi || gate_a_lo || gate_b_hi || gate_b_lo)); // R1
endmodule

// File: tb/test_hbridge_supervisor.sv
module test_hbridge_supervisor;
    localparam int SYNC = 2;
    localparam int DEAD = 2;
    localparam int PULSE = 3;
    localparam int ILIM = 40;
    localparam int OCP = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic dir_a = 0, dir_b = 0, pwm_on = 1, ilim_flag = 0, ocp_flag = 0, ot_flag = 0, uv_flag = 0;
    logic gate_a_hi, gate_a_lo, gate_b_hi, gate_b_lo, bridge_active, fault_n;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #5 clk = ~clk;

    hbridge_supervisor #(
        .SYNC_STAGES(SYNC), .DEAD_CYCLES(DEAD), .PULSE_CYCLES(PULSE),
        .ILIM_CYCLES(ILIM), .OCP_CYCLES(OCP)
    ) i_hbridge_supervisor (
        .clk(clk), .rst_n(rst_n), .dir_a(dir_a), .dir_b(dir_b), .pwm_on(pwm_on),
        .ilim_flag(ilim_flag), .ocp_flag(ocp_flag), .ot_flag(ot_flag), .uv_flag(uv_flag),
        .gate_a_hi(gate_a_hi), .gate_a_lo(gate_a_lo), .gate_b_hi(gate_b_hi),
        .gate_b_lo(gate_b_lo), .bridge_active(bridge_active), .fault_n(fault_n)
    );

    // {a_hi, a_lo, b_hi, b_lo} expected in steady state
    function automatic logic [3:0] exp_gates(input logic a, input logic b, input logic pwm, input logic ot);
        if (ot) return 4'b0000;
        case ({a, b})
            2'b00:   return 4'b0000;
            2'b10:   return pwm ? 4'b1001 : 4'b1010;
            2'b01:   return pwm ? 4'b0110 : 4'b1010;
            default: return 4'b1010;
        endcase
    endfunction

    function automatic logic exp_active(input logic a, input logic b, input logic ot);
        return (a || b) && !ot;
    endfunction

    function automatic logic [3:0] gates();
        return {gate_a_hi, gate_a_lo, gate_b_hi, gate_b_lo};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic cmd(input logic a, input logic b, input logic p);
        dir_a = a; dir_b = b; pwm_on = p;
    endtask

    initial begin
        int a_off, b_off, both_on, low_cnt;
        step(3);
        chk("R1 reset gates", gates(), 4'b0000);
        chk("R9 reset fault_n", fault_n, 1'b1);
        rst_n = 1'b1;
        step(2);
        chk("R10 idle active", bridge_active, 1'b0);

        // constrained random: command, strobe and overtemperature held to settle
        void'($urandom(32'd2024));
        for (int i = 0; i < 200; i++) begin
            logic ra, rb, rp, ro;
            ra = $urandom_range(0, 1);
            rb = $urandom_range(0, 1);
            rp = $urandom_range(0, 1);
            ro = ($urandom_range(0, 4) == 0);
            cmd(ra, rb, rp);
            ot_flag = ro;
            step(14);
            chk("R1 R2 R7 random gates", gates(), exp_gates(ra, rb, rp, ro));
            chk("R10 random active", bridge_active, exp_active(ra, rb, ro));
            chk("R7 R9 random fault_n", fault_n, !ro);
        end
        ot_flag = 0;

        // R4 latency from idle
        cmd(0, 0, 1); step(12);
        cmd(1, 0, 1);
        step(SYNC);
        chk("R4 before latency", gates(), 4'b0000);
        step(1);
        chk("R4 at latency", gates(), 4'b1001);
        step(10);

        // R9 sleep-exit pulse width, into brake
        cmd(0, 0, 1); step(12);
        cmd(1, 1, 1);
        low_cnt = 0;
        for (int k = 0; k < 20; k++) begin step(1); if (!fault_n) low_cnt++; end
        chk("R9 pulse width", low_cnt, PULSE);
        chk("R1 brake", gates(), 4'b1010);

        // R3 dead time forward -> reverse
        cmd(1, 0, 1); step(14);
        cmd(0, 1, 1);
        a_off = 0; both_on = 0;
        for (int k = 0; k < 16; k++) begin
            step(1);
            if (!gate_a_hi && !gate_a_lo) a_off++;
            if ((gate_a_hi && gate_a_lo) || (gate_b_hi && gate_b_lo)) both_on++;
        end
        chk("R3 leg A gap", a_off, DEAD);
        chk("R3 no overlap", both_on, 0);
        chk("R1 reverse", gates(), 4'b0110);

        // R2 pwm off recirculation
        cmd(1, 0, 1); step(14);
        pwm_on = 0;
        b_off = 0;
        for (int k = 0; k < 12; k++) begin step(1); if (!gate_b_hi && !gate_b_lo) b_off++; end
        chk("R2 recirculate", gates(), 4'b1010);
        chk("R3 leg B gap", b_off, DEAD);
        pwm_on = 1; step(10);

        // R5 current limit persistence
        ilim_flag = 1;
        step(ILIM - 1);
        chk("R5 before limit", fault_n, 1'b1);
        step(1);
        chk("R5 at limit", fault_n, 1'b0);
        chk("R5 keeps driving", gates(), 4'b1001);
        chk("R10 active under limit", bridge_active, 1'b1);
        ilim_flag = 0;
        step(1);
        chk("R5 self clear", fault_n, 1'b1);
        ilim_flag = 1;
        step(ILIM + 2);
        chk("R5 again", fault_n, 1'b0);
        cmd(0, 0, 1);
        step(SYNC + 3);
        chk("R5 idle clears", fault_n, 1'b1);
        ilim_flag = 0;
        cmd(1, 0, 1); step(14);

        // R7 overtemperature
        ot_flag = 1;
        step(1);
        chk("R7 fault", fault_n, 1'b0);
        step(DEAD + 2);
        chk("R7 gates off", gates(), 4'b0000);
        ot_flag = 0;
        step(DEAD + 3);
        chk("R7 resume", gates(), 4'b1001);
        chk("R7 fault released", fault_n, 1'b1);

        // R6 overcurrent latch
        ocp_flag = 1;
        step(OCP - 1);
        chk("R6 before filter", fault_n, 1'b1);
        step(1);
        chk("R6 at filter", fault_n, 1'b0);
        step(1);
        chk("R6 gates off", gates(), 4'b0000);
        ocp_flag = 0;
        cmd(0, 0, 1); step(10);
        cmd(1, 0, 1); step(15);
        chk("R6 latched gates", gates(), 4'b0000);
        chk("R6 latched fault", fault_n, 1'b0);
        chk("R10 latched active", bridge_active, 1'b0);

        // R8 undervoltage clears latch
        uv_flag = 1;
        step(2);
        chk("R8 fault", fault_n, 1'b0);
        chk("R8 gates off", gates(), 4'b0000);
        uv_flag = 0;
        step(20);
        chk("R8 recovered gates", gates(), 4'b1001);
        chk("R8 recovered fault", fault_n, 1'b1);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule